// File: doc/BRIEF.md
# Programmable Sum-of-Products Array

This block is the logic core of a small programmable logic device. Twenty-two input signals, twelve dedicated and ten fed back from the device's output side, are each split into a true line and a complement line. The result is a 44-line bus that crosses a field of 133 product-term rows. Each row holds one connection bit per line. A row evaluates to the AND of every line it is connected to. A fixed OR plane then sums groups of these rows into ten outputs, and each output's group has its own size. Thirteen further rows are brought out directly as control terms: ten output-enable terms and three global terms for a synchronous preset, an asynchronous clear and a clock.

The connection bitmap is loaded through a word-wide configuration port. Each write replaces one 44-bit row, and a single-cycle erase strobe opens every connection at once. A small command decoder classifies each cycle's configuration request into one of four commands. `CMD_HOLD` means nothing is requested. `CMD_ERASE` means the erase strobe is high, and erase takes priority. `CMD_LOAD` means a write to an existing row. `CMD_REJECT` means a write to an address past the last row. Only `CMD_ERASE` and `CMD_LOAD` change the bitmap, and they do so on the next rising clock edge. The logic path from the inputs to the outputs holds no registers.

The block is used by loading a pattern after an erase. A row left fully open reads TRUE, so the loader must connect every cell of a sum row it does not use, which forces that row to FALSE.

Top module: `pla_core`

## Requirements
- R1: Line 2i carries signal i and line 2i+1 carries its complement. Signals 0 to 11 are `ded_i[0..11]` and signals 12 to 21 are `fb_i[0..9]`. Reset leaves every connection open.
- R2: A product term is the AND of the lines whose connection bit is 1. A row with no connections reads TRUE whatever the inputs are.
- R3: A row connected to both the true line and the complement line of any one signal reads FALSE for every input value.
- R4: Rows 0 to 119 are the sum terms, laid out back to back. Outputs 0 to 9 own 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 consecutive rows in that order, so output k's first row is the total of the counts before it. `sum_o[k]` is the OR of the rows that output k owns.
- R5: Row 120+k drives `oe_o[k]`. Row 130 drives `preset_o`, row 131 drives `clear_o` and row 132 drives `clk_term_o`.
- R6: A high `cfg_erase_i` opens every connection at the next rising edge. When a write and an erase arrive in the same cycle, the erase wins.
- R7: A high `cfg_we_i` with `cfg_addr_i` below 133 replaces that row with `cfg_row_i` at the next rising edge. A write to address 133 or above changes nothing.
- R8: Outputs follow the inputs with no clock in the path. A configuration write is not visible before its clock edge and is visible after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the array erased |
| ded_i | input | 12 | Dedicated input signals 0 to 11 |
| fb_i | input | 10 | Feedback signals, used as signals 12 to 21 |
| cfg_erase_i | input | 1 | Erase strobe; opens every connection |
| cfg_we_i | input | 1 | Row write enable |
| cfg_addr_i | input | 8 | Row address of a write |
| cfg_row_i | input | 44 | Connection bits of the row, one per line |
| sum_o | output | 10 | OR-plane outputs |
| oe_o | output | 10 | Output-enable terms |
| preset_o | output | 1 | Global synchronous preset term |
| clear_o | output | 1 | Global asynchronous clear term |
| clk_term_o | output | 1 | Clock product term |

## Verification
Some behaviours are checked by assertions on every cycle. Every open row must read TRUE and every row holding a contradictory pair must read FALSE. An erase must leave all 133 terms TRUE on the following cycle. A load must land in the addressed row, and the bitmap must stay unchanged in any cycle that is neither an erase nor a load. Other behaviours only the bench's scenarios can show. These are the line ordering, the uneven row allocation across the ten OR gates, the mapping of the control rows, erase priority seen at the outputs, and the fact that a write is invisible until its clock edge while input changes pass straight through.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int N_DED     = 12;
    localparam int N_FB      = 10;
    localparam int N_SIG     = N_DED + N_FB;
    localparam int N_LINES   = 2 * N_SIG;
    localparam int N_OUT     = 10;
    localparam int MIN_TERMS = 8;
    localparam int TERM_STEP = 2;

    // Terms per OR gate: rising from the first output to the middle, mirrored after.
    function automatic int terms_of(input int k);
        int m;
        m = (k < N_OUT / 2) ? k : (N_OUT - 1 - k);
        return MIN_TERMS + TERM_STEP * m;
    endfunction

    // First sum row owned by output k.
    function automatic int base_of(input int k);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++) begin
            acc += terms_of(i);
        end
        return acc;
    endfunction

    localparam int N_SUM      = base_of(N_OUT);
    localparam int ROW_OE     = N_SUM;
    localparam int ROW_PRESET = N_SUM + N_OUT;
    localparam int ROW_CLEAR  = ROW_PRESET + 1;
    localparam int ROW_CLOCK  = ROW_PRESET + 2;
    localparam int N_ROWS     = ROW_PRESET + 3;
    localparam int ADDR_W     = $clog2(N_ROWS);

    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_ERASE,
        CMD_LOAD,
        CMD_REJECT
    } cfg_cmd_e;

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
    import pla_pkg::*;
#(
    parameter int ROWS  = N_ROWS,
    parameter int LINES = N_LINES,
    parameter int AW    = ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        erase_i,
    input  logic                        we_i,
    input  logic [AW-1:0]               addr_i,
    input  logic [LINES-1:0]            row_i,
    output logic [ROWS-1:0][LINES-1:0]  cells_o
);

    localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

    cfg_cmd_e cmd;

    // Command decode: erase has priority over any write.
    always_comb begin
        if (erase_i) begin
            cmd = CMD_ERASE;
        end else if (we_i) begin
            cmd = (addr_i <= LAST_ROW) ? CMD_LOAD : CMD_REJECT;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // Bitmap register: all connections open after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells_o <= '0;
        end else begin
            unique case (cmd)
                CMD_ERASE:  cells_o <= '0;
                CMD_LOAD:   cells_o[addr_i] <= row_i;
                CMD_HOLD,
                CMD_REJECT: begin
                end
            endcase
        end
    end

    // R7: a load lands in the addressed row
    a_r7_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (cells_o[$past(addr_i)] == $past(row_i)));

    // R7: rejected or idle cycles leave the bitmap untouched
    a_r7_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REJECT || cmd == CMD_HOLD) |=> $stable(cells_o));

    // R6: erase wins and clears every cell
    a_r6_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (cells_o == '0));

endmodule

// File: rtl/pla_term_row.sv
module pla_term_row #(
    parameter int LINES = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    input  logic [LINES-1:0] conn_i,
    output logic             term_o
);

    localparam int PAIRS = LINES / 2;

    // A disconnected cell contributes a constant 1 to the AND.
    assign term_o = &(lines_i | ~conn_i);

    logic has_pair;
    always_comb begin
        has_pair = 1'b0;
        for (int p = 0; p < PAIRS; p++) begin
            if (conn_i[2*p] && conn_i[2*p+1]) begin
                has_pair = 1'b1;
            end
        end
    end

    // R2: an open row is always TRUE
    a_r2_open_true: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_i == '0) |-> term_o);

    // R3: true and complement of one signal both connected forces FALSE
    a_r3_pair_false: assert property (@(posedge clk) disable iff (!rst_n)
        has_pair |-> !term_o);

endmodule

// File: rtl/pla_sum_plane.sv
module pla_sum_plane
    import pla_pkg::*;
#(
    parameter int OUTS = N_OUT,
    parameter int SUMS = N_SUM
) (
    input  logic [SUMS-1:0] terms_i,
    output logic [OUTS-1:0] sum_o
);

    for (genvar k = 0; k < OUTS; k++) begin : g_or
        localparam int BASE  = base_of(k);
        localparam int COUNT = terms_of(k);
        assign sum_o[k] = |terms_i[BASE +: COUNT];
    end

endmodule

// File: rtl/pla_core.sv
module pla_core
    import pla_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_DED-1:0]   ded_i,
    input  logic [N_FB-1:0]    fb_i,
    input  logic               cfg_erase_i,
    input  logic               cfg_we_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [N_LINES-1:0] cfg_row_i,
    output logic [N_OUT-1:0]   sum_o,
    output logic [N_OUT-1:0]   oe_o,
    output logic               preset_o,
    output logic               clear_o,
    output logic               clk_term_o
);

    logic [N_SIG-1:0]                 sig;
    logic [N_LINES-1:0]               lines;
    logic [N_ROWS-1:0][N_LINES-1:0]   cells;
    logic [N_ROWS-1:0]                terms;

    assign sig = {fb_i, ded_i};

    // Even line = true, odd line = complement.
    for (genvar i = 0; i < N_SIG; i++) begin : g_lines
        assign lines[2*i]   = sig[i];
        assign lines[2*i+1] = ~sig[i];
    end

    pla_cfg_store #(
        .ROWS  (N_ROWS),
        .LINES (N_LINES),
        .AW    (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase_i (cfg_erase_i),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .row_i   (cfg_row_i),
        .cells_o (cells)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_rows
        pla_term_row #(.LINES(N_LINES)) u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines_i (lines),
            .conn_i  (cells[r]),
            .term_o  (terms[r])
        );
    end

    pla_sum_plane #(
        .OUTS (N_OUT),
        .SUMS (N_SUM)
    ) u_sum (
        .terms_i (terms[N_SUM-1:0]),
        .sum_o   (sum_o)
    );

    assign oe_o       = terms[ROW_OE +: N_OUT];
    assign preset_o   = terms[ROW_PRESET];
    assign clear_o    = terms[ROW_CLEAR];
    assign clk_term_o = terms[ROW_CLOCK];

    // R6: the cycle after an erase every term reads TRUE
    a_r6_erase_all_true: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase_i |=> (&terms));

endmodule

// File: tb/pla_core_test.sv
module pla_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ded = '0;
    logic [9:0]  fb = '0;
    logic        erase = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [43:0] row = '0;
    logic [9:0]  sum_o, oe_o;
    logic        pre_o, clr_o, clkt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pla_core uut (
        .clk(clk), .rst_n(rst_n), .ded_i(ded), .fb_i(fb),
        .cfg_erase_i(erase), .cfg_we_i(we), .cfg_addr_i(addr), .cfg_row_i(row),
        .sum_o(sum_o), .oe_o(oe_o), .preset_o(pre_o), .clear_o(clr_o),
        .clk_term_o(clkt_o)
    );

    // {ded, fb, sum, preset, clear, clock}
    localparam int NV = 6;
    localparam logic [34:0] VEC [NV] = '{
        {12'h000, 10'h000, 10'h201, 1'b0, 1'b1, 1'b0},
        {12'h007, 10'h001, 10'h203, 1'b0, 1'b1, 1'b0},
        {12'h004, 10'h200, 10'h200, 1'b0, 1'b0, 1'b0},
        {12'h818, 10'h201, 10'h003, 1'b1, 1'b0, 1'b1},
        {12'h83C, 10'h000, 10'h000, 1'b1, 1'b1, 1'b0},
        {12'hFFF, 10'h3FF, 10'h003, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [43:0] r);
        @(negedge clk);
        we = 1'b1; addr = a[7:0]; row = r;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic apply(input logic [11:0] d, input logic [9:0] f);
        @(negedge clk);
        ded = d; fb = f;
        #5;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] s_sum, s_oe;
        logic [2:0] s_ctl;
        repeat (3) @(negedge clk);
        // R1 R2: reset leaves all rows open -> everything TRUE
        apply(12'hA5C, 10'h2B3);
        check("R1 reset sum", sum_o, 10'h3FF);
        check("R2 reset oe", oe_o, 10'h3FF);
        check("R2 reset ctl", {pre_o, clr_o, clkt_o}, 3'b111);
        rst_n = 1'b1;

        // program: unused sum rows all connected (FALSE)
        for (int i = 0; i < 120; i++) wr(i, '1);
        wr(0, 44'h5);                       // ded0 & ded1
        wr(7, 44'd1 << 5);                  // ~ded2
        wr(8, 44'd1 << 24);                 // fb0
        wr(119, 44'd1 << 23);               // ~ded11
        wr(121, '1);                        // oe1 off
        wr(130, 44'd1 << 6);                // preset = ded3
        wr(131, 44'd1 << 43);               // clear = ~fb9
        wr(132, (44'd1 << 8) | (44'd1 << 11)); // clock = ded4 & ~ded5

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][34:23], VEC[v][22:13]);
            check("R4 table sum", sum_o, VEC[v][12:3]);
            check("R5 table ctl", {pre_o, clr_o, clkt_o}, VEC[v][2:0]);
            check("R5 table oe", oe_o, 10'h3FD);
        end

        // R8: write invisible before its edge, visible after
        apply(12'h000, 10'h000);
        check("R8 before write", clkt_o, 1'b0);
        @(negedge clk);
        we = 1'b1; addr = 8'd132; row = '0;
        #5;
        check("R8 pre-edge", clkt_o, 1'b0);
        @(posedge clk); #5;
        check("R8 post-edge", clkt_o, 1'b1);
        @(negedge clk); we = 1'b0;

        // R3: contradictory pair forces FALSE
        wr(130, 44'hC0);
        apply(12'h008, 10'h000);
        check("R3 pair, ded3=1", pre_o, 1'b0);
        apply(12'h000, 10'h000);
        check("R3 pair, ded3=0", pre_o, 1'b0);

        // R7: out-of-range writes ignored
        apply(12'h007, 10'h001);
        s_sum = sum_o; s_oe = oe_o; s_ctl = {pre_o, clr_o, clkt_o};
        wr(133, '1);
        wr(255, '1);
        #5;
        check("R7 oob sum", sum_o, s_sum);
        check("R7 oob oe", oe_o, s_oe);
        check("R7 oob ctl", {pre_o, clr_o, clkt_o}, s_ctl);

        // R6: erase beats a same-cycle write
        @(negedge clk);
        erase = 1'b1; we = 1'b1; addr = 8'd0; row = '1;
        @(negedge clk);
        erase = 1'b0; we = 1'b0;
        #5;
        check("R6 priority sum", sum_o, 10'h3FF);
        check("R6 priority oe", oe_o, 10'h3FF);
        check("R6 priority ctl", {pre_o, clr_o, clkt_o}, 3'b111);

        // R4: uneven allocation boundaries
        for (int i = 0; i < 120; i++) wr(i, '1);
        #5;
        check("R4 all closed", sum_o, 10'h000);
        wr(59, '0);  #5; check("R4 row59 -> out4", sum_o, 10'h010);
        wr(60, '0);  #5; check("R4 row60 -> out5", sum_o, 10'h030);
        wr(43, '0);  #5; check("R4 row43 -> out3", sum_o, 10'h038);
        wr(119, '0); #5; check("R4 row119 -> out9", sum_o, 10'h238);

        // R6: erase alone reopens everything
        wr(121, '1);
        @(negedge clk); erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        apply(12'h3C3, 10'h155);
        check("R6 erase sum", sum_o, 10'h3FF);
        check("R6 erase oe", oe_o, 10'h3FF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule